// File: doc/BRIEF.md
# GPIO Interrupt Routing Mux

This block sits between three GPIO banks and the platform interrupt controller. The banks hold 14, 24 and 32 pins, which makes 70 interrupt requests. Only 41 upstream inputs are available for them. Of these, 38 are dedicated lines that each carry exactly one pin. The other 3 are shared lines, one per bank. A shared line is the OR of every pin of its bank that has no dedicated line at that moment.

A single 32-bit configuration word decides which bank owns each of the 32 tradable dedicated lines. Line `k` with `k < 14` is shared between bank-0 pin `k` and bank-2 pin `k`. Line `k` with `14 <= k < 32` is shared between bank-1 pin `k-14` and bank-2 pin `k`. The last six dedicated lines, 32 to 37, always carry bank-1 pins 18 to 23. Software writes the word once, or now and then, through a small register port. The routing itself is pure combinational logic, so a request reaches its output in the same cycle it arrives.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the configuration word is 0x0000_0000. Reading it at byte offset 0x54 returns zero, so every bank-0 and bank-1 pin has a dedicated line and all of bank 2 is on its shared line.
- R2: A write with `cfg_we` high and `cfg_addr` equal to 0x54 loads `cfg_wdata` on that clock edge. From then on, a read at 0x54 returns the stored word on `cfg_rdata` in the same cycle.
- R3: A write to any address other than 0x54 leaves the configuration word unchanged. The routing and the read-back value stay as they were.
- R4: For line k in 0..13, `irq_ded[k]` follows bank-0 pin k when config bit k is 0, and bank-2 pin k when the bit is 1.
- R5: For line k in 14..31, `irq_ded[k]` follows bank-1 pin k-14 when config bit k is 0, and bank-2 pin k when the bit is 1.
- R6: Lines 32..37 always follow bank-1 pins 18..23, whatever the configuration.
- R7: `irq_shr[0]` is the OR of the bank-0 pins k whose config bit k is 1.
- R8: `irq_shr[1]` is the OR of the bank-1 pins j in 0..17 whose config bit j+14 is 1. Pins 18..23 never reach it.
- R9: `irq_shr[2]` is the OR of the bank-2 pins k whose config bit k is 0.
- R10: The outputs follow the pin inputs in the same cycle. A new configuration changes the routing only after the clock edge that stores it.
- R11: A read at any address other than 0x54 returns zero.
- R12: Each source pin drives exactly one output. With a single pin high, exactly one of the 41 outputs is high. With no pin high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe of the configuration port |
| cfg_addr | input | 12 | Byte address of the configuration port |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational |
| gpio_b0 | input | 14 | Interrupt requests of bank 0 |
| gpio_b1 | input | 24 | Interrupt requests of bank 1 |
| gpio_b2 | input | 32 | Interrupt requests of bank 2 |
| irq_ded | output | 38 | Dedicated upstream lines |
| irq_shr | output | 3 | Shared upstream line per bank (bit n = bank n) |

## Verification
The assertions assume that the pin inputs and the register port are driven to known levels in every sampled cycle after reset. They also assume that a write is a single-cycle strobe whose address and data are stable at the edge. The stimulus changes every input just after a rising edge and samples on the falling edge, so each value it applies is settled well before the edge that uses it. The pin patterns cover every single pin alone, all pins together, zero, and pseudo-random mixes, under all-zero, all-one and mixed configuration words.

// File: rtl/gpio_irq_router_pkg.sv
package gpio_irq_router_pkg;

  // Number of source banks; each bank owns one shared upstream line.
  localparam int unsigned NUM_BANKS = 3;

  // Pitch of the flat source numbering: bank * BANK_PITCH + pin.
  localparam int unsigned BANK_PITCH = 32;

  // Flat 7-bit source number of a pin.
  function automatic logic [6:0] src_id(input int unsigned bank, input int unsigned pin);
    int unsigned v;
    v = bank * BANK_PITCH + pin;
    return v[6:0];
  endfunction

  // Dedicated line that bank-1 pin 'pin' would use, given the bank-0 width.
  function automatic int unsigned b1_line(input int unsigned b0_w, input int unsigned pin);
    return b0_w + pin;
  endfunction

  // True when a dedicated line is one the configuration word can trade.
  function automatic bit line_tradable(input int unsigned line, input int unsigned sel_w);
    return line < sel_w;
  endfunction

endpackage

// File: rtl/irqmux_cfg_reg.sv
module irqmux_cfg_reg #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h054
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] cfg,
  output logic              hit
);

  logic [DATA_W-1:0] cfg_q;

  assign hit = (addr == CFG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we && hit) begin
      cfg_q <= wdata;
    end
  end

  assign cfg   = cfg_q;
  assign rdata = hit ? cfg_q : '0;

endmodule

// File: rtl/irqmux_line_route.sv
module irqmux_line_route
  import gpio_irq_router_pkg::*;
#(
  parameter int unsigned B0_W = 14,
  parameter int unsigned B1_W = 24,
  parameter int unsigned B2_W = 32,
  localparam int unsigned DED_W = B0_W + B1_W,
  localparam int unsigned SEL_W = B2_W
) (
  input  logic [B0_W-1:0]  b0,
  input  logic [B1_W-1:0]  b1,
  input  logic [B2_W-1:0]  b2,
  input  logic [SEL_W-1:0] cfg,
  output logic [DED_W-1:0] ded,
  output logic [B0_W-1:0]  own0,
  output logic [B1_W-1:0]  own1,
  output logic [B2_W-1:0]  own2
);

  // Dedicated line drivers, one per line.
  for (genvar k = 0; k < DED_W; k++) begin : g_line
    if (k < B0_W) begin : g_b0
      assign ded[k] = cfg[k] ? b2[k] : b0[k];
    end else if (line_tradable(k, SEL_W)) begin : g_b1_trade
      assign ded[k] = cfg[k] ? b2[k] : b1[k-B0_W];
    end else begin : g_b1_fixed
      assign ded[k] = b1[k-B0_W];
    end
  end

  // Ownership masks: a set bit means the pin is on a dedicated line.
  for (genvar p = 0; p < B0_W; p++) begin : g_own0
    assign own0[p] = ~cfg[p];
  end

  for (genvar p = 0; p < B1_W; p++) begin : g_own1
    if (line_tradable(b1_line(B0_W, p), SEL_W)) begin : g_trade
      assign own1[p] = ~cfg[b1_line(B0_W, p)];
    end else begin : g_fixed
      assign own1[p] = 1'b1;
    end
  end

  for (genvar p = 0; p < B2_W; p++) begin : g_own2
    assign own2[p] = cfg[p];
  end

endmodule

// File: rtl/irqmux_share_or.sv
module irqmux_share_or #(
  parameter int unsigned W = 14
) (
  input  logic [W-1:0] pins,
  input  logic [W-1:0] owned,
  output logic         shr
);

  logic [W-1:0] leftover;

  assign leftover = pins & ~owned;
  assign shr      = |leftover;

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h054,
  parameter int unsigned B0_W = 14,
  parameter int unsigned B1_W = 24,
  parameter int unsigned B2_W = 32,
  localparam int unsigned DATA_W = B2_W,
  localparam int unsigned DED_W  = B0_W + B1_W,
  localparam int unsigned SHR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [B0_W-1:0]   gpio_b0,
  input  logic [B1_W-1:0]   gpio_b1,
  input  logic [B2_W-1:0]   gpio_b2,
  output logic [DED_W-1:0]  irq_ded,
  output logic [SHR_W-1:0]  irq_shr
);

  logic [DATA_W-1:0] cfg_q;
  logic              cfg_hit;
  logic [B0_W-1:0]   own0;
  logic [B1_W-1:0]   own1;
  logic [B2_W-1:0]   own2;

  irqmux_cfg_reg #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CFG_ADDR(CFG_ADDR)
  ) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .addr (cfg_addr),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .cfg  (cfg_q),
    .hit  (cfg_hit)
  );

  irqmux_line_route #(
    .B0_W(B0_W),
    .B1_W(B1_W),
    .B2_W(B2_W)
  ) u_route (
    .b0  (gpio_b0),
    .b1  (gpio_b1),
    .b2  (gpio_b2),
    .cfg (cfg_q),
    .ded (irq_ded),
    .own0(own0),
    .own1(own1),
    .own2(own2)
  );

  irqmux_share_or #(.W(B0_W)) u_shr0 (.pins(gpio_b0), .owned(own0), .shr(irq_shr[0]));
  irqmux_share_or #(.W(B1_W)) u_shr1 (.pins(gpio_b1), .owned(own1), .shr(irq_shr[1]));
  irqmux_share_or #(.W(B2_W)) u_shr2 (.pins(gpio_b2), .owned(own2), .shr(irq_shr[2]));

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned B0_W = 14,
  parameter int unsigned B1_W = 24,
  parameter int unsigned B2_W = 32,
  localparam int unsigned DATA_W = B2_W,
  localparam int unsigned DED_W  = B0_W + B1_W,
  localparam int unsigned N_IN   = B0_W + B1_W + B2_W,
  localparam int unsigned N_OUT  = DED_W + 3,
  localparam int unsigned N_FIX  = DED_W - B2_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic              hit,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] cfg,
  input logic [B0_W-1:0]   b0,
  input logic [B1_W-1:0]   b1,
  input logic [B2_W-1:0]   b2,
  input logic [DED_W-1:0]  ded,
  input logic [2:0]        shr
);

  logic             wr_seen;
  logic [N_IN-1:0]  all_in;
  logic [N_OUT-1:0] all_out;

  assign all_in  = {b2, b1, b0};
  assign all_out = {shr, ded};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= 1'b0;
    else if (we && hit) wr_seen <= 1'b1;
  end

  // R1: untouched register holds the reset value
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_seen |-> cfg == '0);

  // R2: a matching write is stored by the next cycle
  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit) |=> cfg == $past(wdata));

  // R3: without a matching write the word does not move
  assert_write_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit) |=> $stable(cfg));

  // R6: top dedicated lines always carry the fixed bank-1 pins
  assert_fixed_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ded[DED_W-1 -: N_FIX] == b1[B1_W-1 -: N_FIX]);

  // R12: one active source gives one active output
  assert_single_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(all_in) == 1 |-> $countones(all_out) == 1);

  // R12: no active source gives no active output
  assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    all_in == '0 |-> all_out == '0);

endmodule

bind gpio_irq_router gpio_irq_router_chk #(
  .ADDR_W(ADDR_W),
  .B0_W  (B0_W),
  .B1_W  (B1_W),
  .B2_W  (B2_W)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .we   (cfg_we),
  .hit  (cfg_hit),
  .wdata(cfg_wdata),
  .cfg  (cfg_q),
  .b0   (gpio_b0),
  .b1   (gpio_b1),
  .b2   (gpio_b2),
  .ded  (irq_ded),
  .shr  (irq_shr)
);

// File: tb/sim_gpio_irq_router.sv
module sim_gpio_irq_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [13:0] gpio_b0 = '0;
  logic [23:0] gpio_b1 = '0;
  logic [31:0] gpio_b2 = '0;
  logic [37:0] irq_ded;
  logic [2:0]  irq_shr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] model_cfg = '0;
  bit compare_on = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  gpio_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gpio_b0(gpio_b0),
    .gpio_b1(gpio_b1), .gpio_b2(gpio_b2), .irq_ded(irq_ded), .irq_shr(irq_shr)
  );

  // Reference register: R1 reset, R2 matching write, R3 other writes dropped
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_cfg <= '0;
    else if (cfg_we && cfg_addr == 12'h054) model_cfg <= cfg_wdata;
  end

  // Source-centred reference: find where each active pin lands (R4..R9)
  function automatic logic [40:0] expect_out(logic [31:0] c, logic [13:0] a,
                                             logic [23:0] b, logic [31:0] d);
    logic [40:0] o = '0;
    for (int s = 0; s < 96; s++) begin
      int bank = s / 32;
      int pin  = s % 32;
      int dest = -1;
      if (bank == 0 && pin < 14 && a[pin])
        dest = c[pin] ? 38 : pin;
      else if (bank == 1 && pin < 24 && b[pin])
        dest = (pin >= 18) ? 14 + pin : (c[14+pin] ? 39 : 14 + pin);
      else if (bank == 2 && d[pin])
        dest = c[pin] ? pin : 40;
      if (dest >= 0) o[dest] = 1'b1;
    end
    return o;
  endfunction

  function automatic string req_of(int idx);
    if (idx < 14) return "R4";
    if (idx < 32) return "R5";
    if (idx < 38) return "R6";
    if (idx == 38) return "R7";
    if (idx == 39) return "R8";
    return "R9";
  endfunction

  // Per-clock comparison against the model, sampled on the falling edge
  always @(negedge clk) begin
    if (compare_on) begin
      logic [40:0] exp_o;
      logic [40:0] got_o;
      logic [31:0] exp_rd;
      exp_o  = expect_out(model_cfg, gpio_b0, gpio_b1, gpio_b2);
      got_o  = {irq_shr, irq_ded};
      exp_rd = (cfg_addr == 12'h054) ? model_cfg : 32'h0;
      checks++;
      if (got_o !== exp_o) begin
        fails++;
        for (int i = 0; i < 41; i++)
          if (got_o[i] !== exp_o[i])
            $display("FAIL %s (R10 timing) output %0d: got %b expected %b", req_of(i), i, got_o[i], exp_o[i]);
      end
      checks++;
      if (cfg_rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s read addr %h: got %h expected %h",
                 (cfg_addr == 12'h054) ? "R2" : "R11", cfg_addr, cfg_rdata, exp_rd);
      end
    end
  end

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_cfg(logic [11:0] a, logic [31:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_addr = 12'h054;
  endtask

  task automatic set_pins(logic [13:0] a, logic [23:0] b, logic [31:0] d);
    @(posedge clk); #1;
    gpio_b0 = a; gpio_b1 = b; gpio_b2 = d;
  endtask

  // R12: walk one pin at a time through all 70 sources
  task automatic walk_single();
    for (int s = 0; s < 70; s++) begin
      logic [13:0] a = '0;
      logic [23:0] b = '0;
      logic [31:0] d = '0;
      if (s < 14) a[s] = 1'b1;
      else if (s < 38) b[s-14] = 1'b1;
      else d[s-38] = 1'b1;
      set_pins(a, b, d);
      @(negedge clk);
      check("R12", 64'($countones({irq_shr, irq_ded})), 64'd1);
    end
  endtask

  initial begin
    cfg_addr = 12'h054;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset value and all-quiet outputs
    check("R1", 64'(cfg_rdata), 64'h0);
    check("R1", 64'({irq_shr, irq_ded}), 64'h0);
    compare_on = 1'b1;

    walk_single();
    set_pins('1, '1, '1);
    @(negedge clk);
    check("R1", 64'({irq_shr, irq_ded}), {23'h0, 3'b100, 38'h3f_ffff_ffff});

    // R10: new word not visible in the cycle it is written
    set_pins('0, '0, 32'h0000_0001);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R10", 64'(irq_shr), 64'd4);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    @(negedge clk);
    check("R10", 64'(irq_ded[0]), 64'd1);
    check("R2", 64'(cfg_rdata), 64'hFFFF_FFFF);

    walk_single();
    set_pins('1, 24'h03_FFFF, '0);
    @(negedge clk);
    check("R7", 64'(irq_shr[0]), 64'd1);
    check("R8", 64'(irq_shr[1]), 64'd1);
    set_pins('0, 24'hFC_0000, '0);
    @(negedge clk);
    check("R8", 64'(irq_shr[1]), 64'd0);
    check("R6", 64'(irq_ded[37:32]), 64'h3F);

    // R3: writes elsewhere leave the word alone
    write_cfg(12'h050, 32'h0);
    write_cfg(12'h058, 32'h1234_5678);
    @(negedge clk);
    check("R3", 64'(cfg_rdata), 64'hFFFF_FFFF);
    set_pins('0, 24'h00_0001, '0);
    @(negedge clk);
    check("R3", 64'(irq_shr[1]), 64'd1);

    // R11: off-address read is zero
    @(posedge clk); #1 cfg_addr = 12'h058;
    @(negedge clk);
    check("R11", 64'(cfg_rdata), 64'h0);
    @(posedge clk); #1 cfg_addr = 12'h054;

    write_cfg(12'h054, 32'hA5A5_3C3C);
    walk_single();
    for (int n = 0; n < 300; n++) begin
      if (n % 50 == 0) write_cfg(12'h054, $urandom);
      set_pins(14'($urandom), 24'($urandom), $urandom);
    end
    // R9: bank-2 pins with clear bits reach the shared line
    write_cfg(12'h054, 32'hFFFF_FFFE);
    set_pins('0, '0, 32'h0000_0001);
    @(negedge clk);
    check("R9", 64'(irq_shr[2]), 64'd1);
    check("R4", 64'(irq_ded[0]), 64'd0);
    write_cfg(12'h054, 32'h0000_4000);
    set_pins('0, 24'h00_0001, 32'h0000_4000);
    @(negedge clk);
    check("R5", 64'(irq_ded[14]), 64'd1);
    check("R5", 64'(irq_shr[1]), 64'd1);

    @(posedge clk);
    compare_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule